// File: doc/BRIEF.md
# Power-Good Window Monitor

This block produces the power-good indication for one output rail of a switching regulator. Analog window comparators elsewhere on the chip compare the feedback voltage against its target and deliver three digital flags: inside a tight ±5% band, outside a wide ±10% band, and above the upper +10% limit. The monitor filters these flags in time, with a long qualification delay before power-good rises and a short one before it falls. The two thresholds give hysteresis, and the two delays make the output slow to claim good health and quick to withdraw it.

Start-up is guarded twice. Nothing qualifies until the soft-start sequencer reports completion, and the rise timer may not start before a blanking interval of 1.7 soft-start times has passed since the channel became active. When power-good is lost because the rail went high, the block asks the PWM sequencer to leave auto-skip and run in forced-PWM mode, so that the low-side switch can pull the output back down. It withdraws that request once the rail is back inside the tight band and power-good is high again. All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `pgood_window_mon`

## Requirements
- R1: While reset is applied, `chan_en` is low or `fault_off` is high, `pgood` and `fpwm_req` are low one clock later. All timers restart, so after the channel becomes active again the full blanking and qualification time must pass before `pgood` can rise.
- R2: After `chan_en` goes high with `fault_off` low, the rise timer may not count until BLANK cycles have passed. BLANK is 1.7 times the soft-start time, rounded up to whole clock cycles. With the flags already good, `pgood` rises at the (BLANK + RISE)-th rising clock edge after activation.
- R3: `pgood` never rises while `ss_done` is low, however long `fb_in_tight` stays high.
- R4: Once qualified, `pgood` rises at the RISE-th consecutive rising edge at which `fb_in_tight` is high and `ss_done` is high. RISE is the 510 µs assertion delay in clock cycles.
- R5: A single cycle with `fb_in_tight` low restarts the rise count from zero.
- R6: `pgood` falls at the FALL-th consecutive rising edge at which `fb_out_wide` is high while `pgood` is high. FALL is the 10 µs deassertion delay in clock cycles.
- R7: A single cycle with `fb_out_wide` low restarts the fall count from zero, so a gap at any position inside the window keeps `pgood` high.
- R8: `fpwm_req` rises in the same clock as `pgood` falls if `fb_over_high` is high at that edge. A fall with `fb_over_high` low leaves `fpwm_req` low.
- R9: While `fpwm_req` is high, it clears on the first rising edge at which `pgood` is already high and `fb_in_tight` is high. This is one clock after `pgood` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low disables and clears the monitor |
| fault_off | input | 1 | High while a protection shutdown holds the channel off |
| ss_done | input | 1 | High once the soft-start ramp has completed |
| fb_in_tight | input | 1 | Feedback within ±5% of target |
| fb_out_wide | input | 1 | Feedback outside ±10% of target |
| fb_over_high | input | 1 | Feedback above +10% of target |
| pgood | output | 1 | Power-good indication, high when the rail is healthy |
| fpwm_req | output | 1 | Request to the PWM sequencer for forced-PWM operation |

## Verification
The checks assume the comparator flags are consistent with one another. `fb_over_high` is never high without `fb_out_wide`, and `fb_in_tight` and `fb_out_wide` are never high together. A flag only changes on the clock that follows the voltage it reports. The stimulus always changes the three flags as one set, driven on the falling clock edge. Every overvoltage case raises `fb_over_high` together with `fb_out_wide` and drops `fb_in_tight` in the same cycle. The gap-position sweep moves a single-cycle break through every position of the fall window, so the restart behaviour is covered at each count value and not only at the ends.

// File: rtl/pgwm_pkg.sv
package pgwm_pkg;

   // Comparator flags grouped as one bundle
   typedef struct packed {
      logic tight;   // inside the ±5% band
      logic wide;    // outside the ±10% band
      logic over;    // above +10%
   } pg_fb_t;

   // Time (num/den microseconds) to clock cycles, rounded up
   function automatic int unsigned cyc_from_us(input longint unsigned clk_hz,
                                               input longint unsigned num,
                                               input longint unsigned den);
      longint unsigned q;
      q = (clk_hz * num + den * 64'd1_000_000 - 64'd1) / (den * 64'd1_000_000);
      return 32'(q);
   endfunction

   // Counter width able to hold the value n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pgwm_run_timer.sv
// Counts consecutive cycles with run high; pulses expire on the LIMIT-th one.
module pgwm_run_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expire
);
   localparam int unsigned W = pgwm_pkg::cnt_width(LIMIT);

   if (LIMIT == 0) begin : g_bad_limit
      $error("pgwm_run_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         hit;

   assign hit    = run && !clr && (cnt_q == W'(LIMIT - 1));
   assign expire = hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || !run || hit)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pgwm_blank_gate.sv
// Start-up blanking: done goes high CYC cycles after clr was last released.
module pgwm_blank_gate #(
   parameter int unsigned CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int unsigned W = pgwm_pkg::cnt_width(CYC);

   if (CYC == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, clr};
      assign done = 1'b1;
   end else begin : g_cnt
      logic [W-1:0] cnt_q;
      logic         full;
      assign full = (cnt_q == W'(CYC));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clr)
            cnt_q <= '0;
         else if (!full)
            cnt_q <= cnt_q + 1'b1;
      end
      assign done = full;
   end
endmodule

// File: rtl/pgwm_fpwm_ctl.sv
// Forced-PWM request: set on an overvoltage drop, cleared once healthy again.
module pgwm_fpwm_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic drop_evt,
   input  logic over,
   input  logic pg_now,
   input  logic tight,
   output logic req
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_q <= 1'b0;
      else if (!active)
         req_q <= 1'b0;
      else if (drop_evt && over)
         req_q <= 1'b1;
      else if (pg_now && tight)
         req_q <= 1'b0;
   end

   assign req = req_q;
endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon #(
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned RISE_US     = 510,
   parameter int unsigned FALL_US     = 10,
   parameter int unsigned SS_US       = 1200,
   parameter int unsigned BLANK_NUM   = 17,
   parameter int unsigned BLANK_DEN   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic fault_off,
   input  logic ss_done,
   input  logic fb_in_tight,
   input  logic fb_out_wide,
   input  logic fb_over_high,
   output logic pgood,
   output logic fpwm_req
);
   import pgwm_pkg::*;

   localparam int unsigned RISE_CYC  = cyc_from_us(CLK_HZ, RISE_US, 1);
   localparam int unsigned FALL_CYC  = cyc_from_us(CLK_HZ, FALL_US, 1);
   localparam int unsigned BLANK_CYC =
      cyc_from_us(CLK_HZ, longint'(SS_US) * BLANK_NUM, BLANK_DEN);

   if (BLANK_DEN == 0) begin : g_bad_den
      $error("pgood_window_mon: BLANK_DEN must be nonzero");
   end
   if (RISE_CYC == 0 || FALL_CYC == 0) begin : g_bad_delay
      $error("pgood_window_mon: delays must be at least one cycle");
   end

   pg_fb_t fb;
   logic   active;
   logic   blank_done;
   logic   rise_run, rise_exp;
   logic   fall_run, fall_exp;
   logic   pg_q;

   assign fb     = '{tight: fb_in_tight, wide: fb_out_wide, over: fb_over_high};
   assign active = chan_en && !fault_off;

   pgwm_blank_gate #(.CYC(BLANK_CYC)) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!active),
      .done  (blank_done)
   );

   assign rise_run = !pg_q && ss_done && blank_done && fb.tight;
   assign fall_run = pg_q && fb.wide;

   pgwm_run_timer #(.LIMIT(RISE_CYC)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!active),
      .run    (rise_run),
      .expire (rise_exp)
   );

   pgwm_run_timer #(.LIMIT(FALL_CYC)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!active),
      .run    (fall_run),
      .expire (fall_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pg_q <= 1'b0;
      else if (!active)
         pg_q <= 1'b0;
      else if (rise_exp)
         pg_q <= 1'b1;
      else if (fall_exp)
         pg_q <= 1'b0;
   end

   pgwm_fpwm_ctl u_fpwm (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .drop_evt (fall_exp),
      .over     (fb.over),
      .pg_now   (pg_q),
      .tight    (fb.tight),
      .req      (fpwm_req)
   );

   assign pgood = pg_q;
endmodule

// File: rtl/pgood_window_mon_chk.sv
module pgood_window_mon_chk #(
   parameter int unsigned RISE_CYC  = 4,
   parameter int unsigned FALL_CYC  = 2,
   parameter int unsigned BLANK_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic chan_en,
   input logic fault_off,
   input logic ss_done,
   input logic fb_in_tight,
   input logic fb_out_wide,
   input logic fb_over_high,
   input logic pgood,
   input logic fpwm_req
);
   localparam int unsigned ACT_MAX = BLANK_CYC + RISE_CYC;

   logic        act;
   int unsigned tight_run, wide_run, act_run;

   assign act = chan_en && !fault_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tight_run <= 0;
         wide_run  <= 0;
         act_run   <= 0;
      end else begin
         tight_run <= (act && fb_in_tight && ss_done) ?
                      ((tight_run < RISE_CYC) ? tight_run + 1 : tight_run) : 0;
         wide_run  <= (act && fb_out_wide) ?
                      ((wide_run < FALL_CYC) ? wide_run + 1 : wide_run) : 0;
         act_run   <= act ? ((act_run < ACT_MAX) ? act_run + 1 : act_run) : 0;
      end
   end

   // R1
   inactive_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (!pgood && !fpwm_req));

   // R2
   blank_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> (act_run >= ACT_MAX));

   // R3
   ss_gates_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> $past(ss_done));

   // R4
   rise_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> (tight_run >= RISE_CYC));

   // R6
   fall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pgood) && $past(act)) |-> (wide_run >= FALL_CYC));

   // R8
   fpwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fpwm_req) |-> ($fell(pgood) && $past(fb_over_high)));

   // R9
   fpwm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fpwm_req && pgood && fb_in_tight && act) |=> !fpwm_req);
endmodule

bind pgood_window_mon pgood_window_mon_chk #(
   .RISE_CYC  (RISE_CYC),
   .FALL_CYC  (FALL_CYC),
   .BLANK_CYC (BLANK_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_en      (chan_en),
   .fault_off    (fault_off),
   .ss_done      (ss_done),
   .fb_in_tight  (fb_in_tight),
   .fb_out_wide  (fb_out_wide),
   .fb_over_high (fb_over_high),
   .pgood        (pgood),
   .fpwm_req     (fpwm_req)
);

// File: tb/tb_pgood_window_mon.sv
`timescale 1ns/1ps
module tb_pgood_window_mon;
   localparam int unsigned T_CLK_HZ = 1_000_000;
   localparam int unsigned T_RISE   = 510;
   localparam int unsigned T_FALL   = 10;
   localparam int unsigned T_SS     = 100;

   // Expected cycle counts, from the requirements
   localparam int EXP_RISE  = (T_RISE * (T_CLK_HZ / 1000) + 999) / 1000;
   localparam int EXP_FALL  = (T_FALL * (T_CLK_HZ / 1000) + 999) / 1000;
   localparam int EXP_BLANK = (T_SS * 17 * (T_CLK_HZ / 1000) + 9999) / 10000;

   logic clk = 1'b0;
   logic rst_n, chan_en, fault_off, ss_done;
   logic fb_in_tight, fb_out_wide, fb_over_high;
   logic pgood, fpwm_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pgood_window_mon #(
      .CLK_HZ(T_CLK_HZ), .RISE_US(T_RISE), .FALL_US(T_FALL), .SS_US(T_SS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fault_off(fault_off),
      .ss_done(ss_done), .fb_in_tight(fb_in_tight), .fb_out_wide(fb_out_wide),
      .fb_over_high(fb_over_high), .pgood(pgood), .fpwm_req(fpwm_req)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic flags(input logic t, input logic w, input logic o);
      fb_in_tight = t; fb_out_wide = w; fb_over_high = o;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; chan_en = 1'b0; fault_off = 1'b0; ss_done = 1'b0;
      flags(1'b0, 1'b0, 1'b0);
      step(3);
      chk("R1", "pgood in reset", pgood, 1'b0);
      chk("R1", "fpwm in reset", fpwm_req, 1'b0);
      rst_n = 1'b1;
      ss_done = 1'b1;
      flags(1'b1, 1'b0, 1'b0);
      step(EXP_RISE + 20);
      chk("R1", "pgood with channel disabled", pgood, 1'b0);

      // Power-up: blanking then qualification (R2)
      chan_en = 1'b1;
      step(EXP_BLANK + EXP_RISE - 1);
      chk("R2", "pgood one edge before blank+rise", pgood, 1'b0);
      step(1);
      chk("R2", "pgood at blank+rise", pgood, 1'b1);
      chk("R8", "fpwm after start-up", fpwm_req, 1'b0);

      // Sweep a one-cycle gap through the fall window (R7, R6, R4)
      for (int g = 1; g < EXP_FALL; g++) begin
         flags(1'b0, 1'b1, 1'b0);
         step(g);
         flags(1'b0, 1'b0, 1'b0);
         step(1);
         chk("R7", $sformatf("pgood held across gap %0d", g), pgood, 1'b1);
         flags(1'b0, 1'b1, 1'b0);
         step(EXP_FALL - 1);
         chk("R7", "pgood one edge before restarted fall", pgood, 1'b1);
         step(1);
         chk("R6", "pgood after fall window", pgood, 1'b0);
         chk("R8", "fpwm after fall without overvoltage", fpwm_req, 1'b0);
         flags(1'b1, 1'b0, 1'b0);
         step(EXP_RISE - 1);
         chk("R4", "pgood one edge before rise", pgood, 1'b0);
         step(1);
         chk("R4", "pgood at rise", pgood, 1'b1);
      end

      // Break during qualification restarts the rise count (R5)
      flags(1'b0, 1'b1, 1'b0);
      step(EXP_FALL);
      chk("R6", "pgood low before R5 case", pgood, 1'b0);
      flags(1'b1, 1'b0, 1'b0);
      step(EXP_RISE / 2);
      flags(1'b0, 1'b0, 1'b0);
      step(1);
      flags(1'b1, 1'b0, 1'b0);
      step(EXP_RISE - 1);
      chk("R5", "pgood one edge before restarted rise", pgood, 1'b0);
      step(1);
      chk("R5", "pgood at restarted rise", pgood, 1'b1);

      // Overvoltage excursion and forced PWM (R8, R9)
      flags(1'b0, 1'b1, 1'b1);
      step(EXP_FALL - 1);
      chk("R8", "fpwm before drop", fpwm_req, 1'b0);
      chk("R6", "pgood before overvoltage drop", pgood, 1'b1);
      step(1);
      chk("R8", "pgood after overvoltage drop", pgood, 1'b0);
      chk("R8", "fpwm set with drop", fpwm_req, 1'b1);
      flags(1'b1, 1'b0, 1'b0);
      step(EXP_RISE - 1);
      chk("R9", "fpwm held while pgood low", fpwm_req, 1'b1);
      step(1);
      chk("R9", "pgood back high", pgood, 1'b1);
      chk("R9", "fpwm still high at rise edge", fpwm_req, 1'b1);
      step(1);
      chk("R9", "fpwm cleared one edge later", fpwm_req, 1'b0);

      // Soft-start not done blocks the rise (R3)
      flags(1'b0, 1'b1, 1'b0);
      step(EXP_FALL);
      chk("R6", "pgood low before R3 case", pgood, 1'b0);
      ss_done = 1'b0;
      flags(1'b1, 1'b0, 1'b0);
      step(EXP_RISE + 50);
      chk("R3", "pgood with soft-start incomplete", pgood, 1'b0);
      ss_done = 1'b1;
      step(EXP_RISE - 1);
      chk("R3", "pgood one edge before rise after ss_done", pgood, 1'b0);
      step(1);
      chk("R4", "pgood rise after ss_done", pgood, 1'b1);

      // Fault shutdown clears outputs and timers (R1, R2)
      flags(1'b0, 1'b1, 1'b1);
      step(EXP_FALL);
      chk("R8", "fpwm set before fault", fpwm_req, 1'b1);
      fault_off = 1'b1;
      step(1);
      chk("R1", "pgood under fault", pgood, 1'b0);
      chk("R1", "fpwm under fault", fpwm_req, 1'b0);
      flags(1'b1, 1'b0, 1'b0);
      step(5);
      fault_off = 1'b0;
      step(EXP_BLANK + EXP_RISE - 1);
      chk("R2", "pgood one edge early after fault", pgood, 1'b0);
      step(1);
      chk("R2", "pgood after fault recovery", pgood, 1'b1);

      // Channel disable (R1, R2)
      chan_en = 1'b0;
      step(1);
      chk("R1", "pgood after disable", pgood, 1'b0);
      step(3);
      chan_en = 1'b1;
      step(EXP_BLANK + EXP_RISE - 1);
      chk("R2", "pgood one edge early after re-enable", pgood, 1'b0);
      step(1);
      chk("R2", "pgood after re-enable", pgood, 1'b1);
      chk("R1", "fpwm after re-enable", fpwm_req, 1'b0);

      summary();
   end
endmodule